// File: doc/BRIEF.md
# CSD Constant Coefficient Scaler

This block multiplies a streaming signed sample by a coefficient that is fixed when the design is elaborated. It contains no general multiplier. An elaboration-time function recodes the coefficient into canonical signed-digit form, where every digit is 0, +1 or -1 and no two neighbouring digits are both nonzero. The product is then built as a sum and difference of shifted copies of the sample. Each nonzero digit beyond the first costs exactly one adder or subtractor. For example, 15 is realised as 16 minus 1, which needs one subtractor and two shifts.

The shifted copies form the leaves of a balanced binary tree. Each leaf carries a sign that is known at elaboration. Every tree node is a single adder or subtractor, chosen at elaboration from the signs of its two inputs. If every digit of the coefficient is negative, one negation is applied at the root. The block is meant to sit in a fixed-coefficient datapath that computes products of the form A·X + Y, with the accumulation done downstream.

When `PIPE` is set, a register follows every adder level, and the valid flag is delayed to match. When `PIPE` is clear, the block is purely combinational from `in_data` to `out_prod`.

Top module: `csd_scaler`

## Requirements
- R1: When `out_vld` is high, `out_prod` equals the exact signed product of the accepted sample and `COEF`, as a 24-bit two's-complement value, for every 12-bit input including -2048 × -2048.
- R2: With `PIPE` = 0, `out_vld` and `out_prod` reflect `in_vld` and `in_data` in the same cycle.
- R3: With `PIPE` = 1, the latency is ceil(log2(D)) cycles, where D is the count of nonzero canonical digits (0 cycles when D ≤ 1), and `out_vld` is `in_vld` delayed by exactly that count.
- R4: The recoding is canonical. Coefficient 15 (16 − 1) has D = 2 and a pipelined latency of 1. Coefficient 1365 (six isolated ones) has D = 6 and a latency of 3. Coefficient -683 (−1024 + 256 + 64 + 16 + 4 + 1) has D = 6 and a latency of 3.
- R5: Coefficient 0 gives `out_prod` = 0 at all times, with `out_vld` following `in_vld` at latency 0.
- R6: A single-digit coefficient (+16, -1 or -2048) uses only a shift, plus a negation when the digit is negative, and has latency 0 even when pipelined.
- R7: A coefficient whose digits are all negative (-5 = −4 − 1) gives the correctly signed product after one adder level.
- R8: `out_prod` is zero in every cycle in which `out_vld` is low, whatever `in_data` holds.
- R9: Driving `rst_n` low clears every pipeline register at once, forcing `out_vld` low and `out_prod` to zero.
- R10: A new sample may be accepted every cycle, and results leave in input order with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `in_data` as a sample to scale |
| in_data | input | DATA_W (12) | Signed input sample |
| out_vld | output | 1 | Marks `out_prod` as a result |
| out_prod | output | DATA_W+COEF_W (24) | Signed full-precision product |

## Verification
The assertions check on every cycle the following properties:
- Each valid result matches a reference product taken at the configured latency.
- The root sum never needs its guard bit.
- Idle cycles carry zero data through every adder stage.
- Each pipeline stage passes its valid flag forward by exactly one cycle.

Only the bench's scenarios can show that the digit count, and so the latency, comes out right for specific coefficients, because the assertions merely follow whatever latency the recoding produced. The same applies to asynchronous clearing in mid-stream, to back-to-back streaming across several coefficients at once, and to the zero, power-of-two and all-negative coefficient cases.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

    localparam int MAXD = 32;

    typedef logic [MAXD-1:0] dmask_t;

    typedef struct packed {
        dmask_t neg;
        dmask_t pos;
    } csd_code_t;

    // Canonical signed-digit recoding of a constant over nd digit positions.
    function automatic csd_code_t csd_recode(int coef, int nd);
        csd_code_t c;
        longint    r;
        c.pos = '0;
        c.neg = '0;
        r     = longint'(coef);
        for (int i = 0; i < MAXD; i++) begin
            if (i < nd && r != 0) begin
                if ((r & 64'sd1) != 0) begin
                    if ((r & 64'sd3) == 64'sd1) begin
                        c.pos[i] = 1'b1;
                        r        = r - 64'sd1;
                    end else begin
                        c.neg[i] = 1'b1;
                        r        = r + 64'sd1;
                    end
                end
                r = r >>> 1;
            end
        end
        return c;
    endfunction

    function automatic int csd_count(int coef, int nd);
        csd_code_t c;
        int        n;
        c = csd_recode(coef, nd);
        n = 0;
        for (int i = 0; i < MAXD; i++) begin
            if (c.pos[i] || c.neg[i]) n++;
        end
        return n;
    endfunction

    // Bit position of the k-th nonzero digit, counted from the least significant end.
    function automatic int csd_term_shift(int coef, int nd, int k);
        csd_code_t c;
        int        seen;
        int        pos;
        c    = csd_recode(coef, nd);
        seen = 0;
        pos  = 0;
        for (int i = 0; i < MAXD; i++) begin
            if (c.pos[i] || c.neg[i]) begin
                if (seen == k) pos = i;
                seen++;
            end
        end
        return pos;
    endfunction

    function automatic logic csd_term_neg(int coef, int nd, int k);
        csd_code_t c;
        int        seen;
        logic      ng;
        c    = csd_recode(coef, nd);
        seen = 0;
        ng   = 1'b0;
        for (int i = 0; i < MAXD; i++) begin
            if (c.pos[i] || c.neg[i]) begin
                if (seen == k) ng = c.neg[i];
                seen++;
            end
        end
        return ng;
    endfunction

    function automatic int tree_levels(int n);
        int w;
        int l;
        w = n;
        l = 0;
        for (int s = 0; s < MAXD; s++) begin
            if (w > 1) begin
                w = (w + 1) / 2;
                l++;
            end
        end
        return l;
    endfunction

    function automatic int level_width(int n, int l);
        int w;
        w = n;
        for (int s = 0; s < MAXD; s++) begin
            if (s < l) w = (w + 1) / 2;
        end
        return w;
    endfunction

    // Sign carried by each node at tree level l: negative only if both children are.
    function automatic dmask_t level_signs(int coef, int nd, int l);
        dmask_t s;
        dmask_t t;
        int     n;
        int     w;
        n = csd_count(coef, nd);
        s = '0;
        for (int k = 0; k < MAXD; k++) begin
            if (k < n) s[k] = csd_term_neg(coef, nd, k);
        end
        w = n;
        for (int st = 0; st < MAXD; st++) begin
            if (st < l) begin
                t = '0;
                for (int j = 0; j < MAXD / 2; j++) begin
                    if (2 * j + 1 < w)  t[j] = s[2*j] & s[2*j+1];
                    else if (2 * j < w) t[j] = s[2*j];
                end
                s = t;
                w = (w + 1) / 2;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/csd_term_gen.sv
`timescale 1ns/1ps
module csd_term_gen #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 25,
    parameter int COEF   = 15,
    parameter int ND     = 13,
    parameter int NT     = 2
) (
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_data,
    output logic [NT*ACC_W-1:0]      term_bus
);

    logic signed [ACC_W-1:0] x_ext;

    // Idle samples enter the tree as zero so that no stage carries stale data.
    always_comb begin
        if (in_vld) x_ext = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
        else        x_ext = '0;
    end

    for (genvar k = 0; k < NT; k++) begin : g_term
        localparam int SH = csd_pkg::csd_term_shift(COEF, ND, k);
        assign term_bus[k*ACC_W +: ACC_W] = x_ext <<< SH;
    end

endmodule

// File: rtl/csd_add_stage.sv
`timescale 1ns/1ps
module csd_add_stage #(
    parameter int                  ACC_W = 25,
    parameter int                  NIN   = 2,
    parameter bit                  PIPE  = 1'b0,
    parameter csd_pkg::dmask_t     SIGNS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [NIN*ACC_W-1:0]          in_bus,
    output logic                          out_vld,
    output logic [((NIN+1)/2)*ACC_W-1:0]  out_bus
);

    localparam int NOUT = (NIN + 1) / 2;

    logic [NOUT*ACC_W-1:0] sum_bus;

    for (genvar j = 0; j < NOUT; j++) begin : g_node
        if (2 * j + 1 < NIN) begin : g_pair
            localparam logic SA = SIGNS[2*j];
            localparam logic SB = SIGNS[2*j+1];
            logic signed [ACC_W-1:0] a_val;
            logic signed [ACC_W-1:0] b_val;
            assign a_val = in_bus[(2*j)*ACC_W +: ACC_W];
            assign b_val = in_bus[(2*j+1)*ACC_W +: ACC_W];
            if (SA == SB) begin : g_add
                assign sum_bus[j*ACC_W +: ACC_W] = a_val + b_val;
            end else if (!SA) begin : g_sub_ab
                assign sum_bus[j*ACC_W +: ACC_W] = a_val - b_val;
            end else begin : g_sub_ba
                assign sum_bus[j*ACC_W +: ACC_W] = b_val - a_val;
            end
        end else begin : g_pass
            assign sum_bus[j*ACC_W +: ACC_W] = in_bus[(2*j)*ACC_W +: ACC_W];
        end
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_vld <= 1'b0;
                out_bus <= '0;
            end else begin
                out_vld <= in_vld;
                out_bus <= sum_bus;
            end
        end

        AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld); // R3
        AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld); // R3
    end else begin : g_comb
        assign out_vld = in_vld;
        assign out_bus = sum_bus;
    end

    AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> (sum_bus == '0)); // R8

endmodule

// File: rtl/csd_scaler.sv
`timescale 1ns/1ps
module csd_scaler #(
    parameter int DATA_W = 12,
    parameter int COEF_W = 12,
    parameter int COEF   = 15,
    parameter bit PIPE   = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld,
    input  logic signed [DATA_W-1:0]        in_data,
    output logic                            out_vld,
    output logic signed [DATA_W+COEF_W-1:0] out_prod
);

    localparam int OUT_W  = DATA_W + COEF_W;
    localparam int ACC_W  = OUT_W + 1;
    localparam int ND     = COEF_W + 1;
    localparam int NZ     = csd_pkg::csd_count(COEF, ND);
    localparam int LEVELS = csd_pkg::tree_levels(NZ);
    localparam int LAT    = PIPE ? LEVELS : 0;
    localparam csd_pkg::dmask_t ROOT_SIGNS = csd_pkg::level_signs(COEF, ND, LEVELS);
    localparam logic ROOT_NEG = (NZ > 0) ? ROOT_SIGNS[0] : 1'b0;
    localparam logic signed [COEF_W-1:0] COEF_S = COEF_W'(COEF);

    logic signed [ACC_W-1:0] root_val;
    logic                    root_vld;
    logic signed [ACC_W-1:0] full_val;

    if (NZ == 0) begin : g_zero
        assign root_val = '0;
        assign root_vld = in_vld;
    end else begin : g_tree
        logic [NZ*ACC_W-1:0] term_bus;

        csd_term_gen #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W),
            .COEF   (COEF),
            .ND     (ND),
            .NT     (NZ)
        ) u_terms (
            .in_vld   (in_vld),
            .in_data  (in_data),
            .term_bus (term_bus)
        );

        if (LEVELS == 0) begin : g_single
            assign root_val = term_bus[ACC_W-1:0];
            assign root_vld = in_vld;
        end else begin : g_adders
            for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
                localparam int NIN  = csd_pkg::level_width(NZ, l);
                localparam int NOUT = csd_pkg::level_width(NZ, l + 1);
                localparam csd_pkg::dmask_t SG = csd_pkg::level_signs(COEF, ND, l);
                logic [NOUT*ACC_W-1:0] lvl_bus;
                logic                  lvl_vld;
                if (l == 0) begin : g_head
                    csd_add_stage #(
                        .ACC_W (ACC_W),
                        .NIN   (NIN),
                        .PIPE  (PIPE),
                        .SIGNS (SG)
                    ) u_stage (
                        .clk     (clk),
                        .rst_n   (rst_n),
                        .in_vld  (in_vld),
                        .in_bus  (term_bus),
                        .out_vld (lvl_vld),
                        .out_bus (lvl_bus)
                    );
                end else begin : g_body
                    csd_add_stage #(
                        .ACC_W (ACC_W),
                        .NIN   (NIN),
                        .PIPE  (PIPE),
                        .SIGNS (SG)
                    ) u_stage (
                        .clk     (clk),
                        .rst_n   (rst_n),
                        .in_vld  (g_lvl[l-1].lvl_vld),
                        .in_bus  (g_lvl[l-1].lvl_bus),
                        .out_vld (lvl_vld),
                        .out_bus (lvl_bus)
                    );
                end
            end
            assign root_val = g_lvl[LEVELS-1].lvl_bus[ACC_W-1:0];
            assign root_vld = g_lvl[LEVELS-1].lvl_vld;
        end
    end

    // All-negative digit sets leave a negative root; one negation restores the sign.
    if (ROOT_NEG) begin : g_negate
        assign full_val = -root_val;
    end else begin : g_keep
        assign full_val = root_val;
    end

    assign out_prod = full_val[OUT_W-1:0];
    assign out_vld  = root_vld;

    // Reference product used only by the checks below.
    logic signed [OUT_W-1:0] chk_ref;
    assign chk_ref = in_data * COEF_S;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (full_val[ACC_W-1] == full_val[ACC_W-2])); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_prod == '0)); // R8

    if (LAT == 0) begin : g_chk_comb
        AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> (out_prod == chk_ref)); // R1
    end else begin : g_chk_pipe
        AST_PRODUCT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> (out_prod == $past(chk_ref, LAT))); // R3
    end

endmodule

// File: tb/csd_scaler_bench.sv
`timescale 1ns/1ps
module csd_scaler_bench;

    localparam int NI = 9;
    localparam int HD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [11:0] in_data = '0;

    logic              ov [NI];
    logic signed [23:0] op [NI];

    // Coefficient, expected pipelined latency and requirement tags per instance.
    int    coef_tab [NI] = '{15, 15, 1365, -2048, 0, 16, -1, -5, -683};
    int    lat_tab  [NI] = '{0, 1, 3, 0, 0, 0, 0, 1, 3};
    string tag_tab  [NI] = '{"R1 R2", "R1 R4", "R1 R3 R4", "R6", "R5", "R6", "R6", "R7", "R3 R4"};

    logic hv [HD];
    int   hx [HD];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csd_scaler #(.COEF(15),    .PIPE(1'b0)) u_csd_scaler   (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[0]), .out_prod(op[0]));
    csd_scaler #(.COEF(15),    .PIPE(1'b1)) u_csd_scaler_b (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[1]), .out_prod(op[1]));
    csd_scaler #(.COEF(1365),  .PIPE(1'b1)) u_csd_scaler_c (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[2]), .out_prod(op[2]));
    csd_scaler #(.COEF(-2048), .PIPE(1'b1)) u_csd_scaler_d (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[3]), .out_prod(op[3]));
    csd_scaler #(.COEF(0),     .PIPE(1'b1)) u_csd_scaler_e (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[4]), .out_prod(op[4]));
    csd_scaler #(.COEF(16),    .PIPE(1'b1)) u_csd_scaler_f (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[5]), .out_prod(op[5]));
    csd_scaler #(.COEF(-1),    .PIPE(1'b1)) u_csd_scaler_g (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[6]), .out_prod(op[6]));
    csd_scaler #(.COEF(-5),    .PIPE(1'b1)) u_csd_scaler_h (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[7]), .out_prod(op[7]));
    csd_scaler #(.COEF(-683),  .PIPE(1'b1)) u_csd_scaler_i (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .out_vld(ov[8]), .out_prod(op[8]));

    task automatic clear_hist();
        for (int i = 0; i < HD; i++) begin
            hv[i] = 1'b0;
            hx[i] = 0;
        end
    endtask

    // Each instance must show the sample accepted lat_tab cycles ago, or idle zero (R8).
    task automatic check_all(string scen);
        for (int i = 0; i < NI; i++) begin
            int     l;
            logic   ev;
            longint ex;
            longint ac;
            l  = lat_tab[i];
            ev = hv[l];
            ex = ev ? longint'(hx[l]) * longint'(coef_tab[i]) : 64'sd0;
            ac = longint'(op[i]);
            n_chk++;
            if (ov[i] !== ev || ac != ex) begin
                n_fail++;
                $display("FAIL %s %s coef=%0d: actual vld=%0b prod=%0d expected vld=%0b prod=%0d",
                         tag_tab[i], scen, coef_tab[i], ov[i], ac, ev, ex);
            end
        end
    endtask

    task automatic step(input logic v, input int x, input string scen);
        @(negedge clk);
        in_vld  = v;
        in_data = 12'(x);
        for (int i = HD - 1; i > 0; i--) begin
            hv[i] = hv[i-1];
            hx[i] = hx[i-1];
        end
        hv[0] = v;
        hx[0] = int'(in_data);
        #1;
        check_all(scen);
    endtask

    // R9: outputs held clear while reset is low.
    task automatic t_reset();
        clear_hist();
        rst_n  = 1'b0;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check_all("R9 reset state");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1, R8: extreme inputs, each followed by idle cycles carrying junk data.
    task automatic t_extremes();
        int vals [6] = '{-2048, 2047, -1, 1, 0, 1365};
        foreach (vals[k]) begin
            step(1'b1, vals[k], "R1 extreme");
            for (int n = 0; n < 4; n++) step(1'b0, vals[k] ^ 12'hfff, "R8 idle junk");
        end
    endtask

    // R1: assorted mid-range samples.
    task automatic t_patterns();
        int vals [6] = '{-683, 100, -77, 512, -1366, 777};
        foreach (vals[k]) begin
            step(1'b1, vals[k], "R1 pattern");
            for (int n = 0; n < 4; n++) step(1'b0, 1234 - k, "R8 idle junk");
        end
    endtask

    // R10: one sample every cycle.
    task automatic t_stream();
        for (int k = 0; k < 12; k++) step(1'b1, ((k * 419) % 4096) - 2048, "R10 stream");
        for (int n = 0; n < 4; n++) step(1'b0, 55, "R10 drain");
    endtask

    // R3: valid with gaps must stay aligned with its data.
    task automatic t_alternate();
        for (int k = 0; k < 10; k++) step(k[0] == 1'b0, 300 * k - 1500, "R3 gaps");
        for (int n = 0; n < 4; n++) step(1'b0, 0, "R3 drain");
    endtask

    // R9: asynchronous reset in mid-stream clears every stage at once.
    task automatic t_reset_mid();
        step(1'b1, 1999, "R9 preload");
        step(1'b1, -1999, "R9 preload");
        step(1'b1, 1000, "R9 preload");
        @(negedge clk);
        rst_n  = 1'b0;
        in_vld = 1'b0;
        clear_hist();
        #1;
        check_all("R9 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 4; n++) step(1'b0, 7, "R9 after reset");
        step(1'b1, -300, "R9 restart");
        for (int n = 0; n < 4; n++) step(1'b0, 0, "R9 restart drain");
    endtask

    initial begin
        clear_hist();
        t_reset();
        t_extremes();
        t_patterns();
        t_stream();
        t_alternate();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule